// File: doc/BRIEF.md
# Layer-3 Control Frame Parser

This block sits on the receive side of a private layer-3 link, right after the Ethernet MAC. It accepts frames as a stream of 8-byte beats and decodes the two kinds of frame that a host sends to the device. Both kinds share a 16-byte header: the destination address, the source address, a 16-bit protocol identifier and a 16-bit protocol version. The 16-bit code that follows the header decides the kind. A code of 0x0003 marks an acknowledge frame. Any other value is the opcode of a command frame. The FCS is checked upstream, so this block does not check it.

For each frame that passes the checks, the parser writes one record into a small output queue. An acknowledge record holds the repetition number, the stream packet number and the transmission delay. A command record holds the command code, the sequence number and the argument. Every record also holds the sender's MAC address. The parser drops, without any report, a frame whose identifier or version is wrong and a frame that ends too early. A good frame that finds the queue full is also dropped, and this kind of drop is counted. The input has no back-pressure, so the queue absorbs short stalls of the consumer.

Top module: `ctlframe_parser`

## Requirements
- R1: After reset, out_valid is 0 and drop_cnt is 0.
- R2: A record is produced only when frame bytes 12..13 read 0xFADE and bytes 14..15 read 0x0100. Any other frame leaves the outputs and drop_cnt unchanged.
- R3: When bytes 16..17 are 0x0003, the record has out_is_ack=1 and out_code=0x0003. out_seq takes bytes 18..19, out_arg takes bytes 20..23 and out_delay takes bytes 24..27. All fields are big-endian, with the lower byte offset most significant.
- R4: For any other code in bytes 16..17, the record has out_is_ack=0. out_code takes bytes 16..17, out_seq takes bytes 18..19, out_arg takes bytes 20..23, and out_delay is 0.
- R5: out_src holds frame bytes 6..11, with byte 6 in bits 47:40.
- R6: A frame is dropped when the bytes flagged by in_keep add up to fewer than 28 for an acknowledge or fewer than 24 for a command. No record and no count result.
- R7: A record appears on the outputs only after the beat with in_last=1. out_valid rises in the cycle after the clock edge that accepts that beat.
- R8: Records leave in arrival order. The head record stays unchanged on the outputs while out_ready is 0.
- R9: A valid frame that ends while DEPTH records are pending and no record is taken in that cycle is dropped, and drop_cnt rises by exactly 1 (modulo 2^CNT_W). Frames rejected under R2 or R6 are not counted.
- R10: Frame byte k*LANES+i travels in beat k on lane i, and lane i is in_data[8*(LANES-i)-1 -: 8], qualified by in_keep[i]. Cycles with in_valid=0 inside a frame are ignored.
- R11: A valid frame that ends while the queue is full, in a cycle where the head record is taken, is stored without a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8*LANES | Frame bytes of one beat, lane 0 in the top byte |
| in_valid | input | 1 | Beat is present |
| in_last | input | 1 | Beat ends the frame |
| in_keep | input | LANES | Per-lane byte enable |
| out_valid | output | 1 | A record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_is_ack | output | 1 | 1 for acknowledge, 0 for command |
| out_src | output | 48 | Sender MAC address |
| out_code | output | 16 | Frame code |
| out_seq | output | 16 | Repetition number or command sequence number |
| out_arg | output | 32 | Stream packet number or command argument |
| out_delay | output | 32 | Transmission delay, 0 for commands |
| drop_cnt | output | CNT_W | Frames dropped on a full queue |

## Verification
The assertions check these properties on every cycle:
- The acknowledge and command field rules: the code is 0x0003 exactly for acknowledge records, and out_delay is zero for command records.
- A stalled head record stays stable.
- out_valid rises only after a last beat.
- drop_cnt moves only in steps of one, and only after a last beat that arrives while a record is pending.

Only the bench's scenarios can show that bytes are taken from the right offsets. The same goes for the header and length checks at each side of the 24-byte and 28-byte limits, for idle gaps inside a frame, and for a push and a pop in the same cycle on a full queue.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam logic [15:0] PROTO_ID  = 16'hFADE;
  localparam logic [15:0] PROTO_VER = 16'h0100;
  localparam logic [15:0] ACK_CODE  = 16'h0003;

  // Byte window that holds every field the parser reads
  localparam int HDR_BYTES = 32;
  localparam int OFF_SRC   = 6;
  localparam int OFF_PROTO = 12;
  localparam int OFF_VER   = 14;
  localparam int OFF_CODE  = 16;
  localparam int OFF_SEQ   = 18;
  localparam int OFF_ARG   = 20;
  localparam int OFF_DLY   = 24;
  localparam int ACK_MIN   = 28;
  localparam int CMD_MIN   = 24;

  typedef struct packed {
    logic        is_ack;
    logic [47:0] src;
    logic [15:0] code;
    logic [15:0] seq;
    logic [31:0] arg;
    logic [31:0] delay;
  } rec_t;
endpackage

// File: rtl/cfp_capture.sv
module cfp_capture
  import cfp_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [8*LANES-1:0]     in_data,
  input  logic                   in_valid,
  input  logic                   in_last,
  input  logic [LANES-1:0]       in_keep,
  output logic [8*HDR_BYTES-1:0] view,
  output logic [BYTE_W-1:0]      total,
  output logic                   frame_end
);
  localparam int HDR_BEATS = HDR_BYTES / LANES;
  localparam int BW        = $clog2(HDR_BEATS + 1);
  localparam int KW        = $clog2(LANES + 1);
  localparam logic [BYTE_W-1:0] BMAX = '1;

  logic [BW-1:0]            beat_q;
  logic [BYTE_W-1:0]        bytes_q;
  logic [8*HDR_BYTES-1:0]   hdr_q;
  logic [KW-1:0]            lanes_on;
  logic [BYTE_W:0]          sum;

  always_comb begin
    lanes_on = '0;
    for (int i = 0; i < LANES; i++) lanes_on = lanes_on + KW'(in_keep[i]);
  end

  assign sum   = {1'b0, bytes_q} + (BYTE_W+1)'(lanes_on);
  assign total = sum[BYTE_W] ? BMAX : sum[BYTE_W-1:0];

  // Current beat overlays its slots in the shadow window
  for (genvar j = 0; j < HDR_BYTES; j++) begin : g_byte
    localparam int BEAT = j / LANES;
    localparam int LANE = j % LANES;
    assign view[8*(HDR_BYTES-j)-1 -: 8] =
      (in_valid && beat_q == BW'(BEAT)) ? in_data[8*(LANES-LANE)-1 -: 8]
                                        : hdr_q[8*(HDR_BYTES-j)-1 -: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q  <= '0;
      bytes_q <= '0;
      hdr_q   <= '0;
    end else if (in_valid) begin
      hdr_q <= view;
      if (in_last) begin
        beat_q  <= '0;
        bytes_q <= '0;
      end else begin
        bytes_q <= total;
        if (beat_q != BW'(HDR_BEATS)) beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign frame_end = in_valid && in_last;
endmodule

// File: rtl/cfp_decide.sv
module cfp_decide
  import cfp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [8*HDR_BYTES-1:0] view,
  input  logic [BYTE_W-1:0]      total,
  input  logic                   frame_end,
  output logic                   accept,
  output rec_t                   rec
);
  localparam int TOP = 8 * HDR_BYTES;

  logic [15:0] proto, ver, code;
  logic        is_ack, hdr_ok, long_enough;

  assign proto  = view[TOP-8*OFF_PROTO-1 -: 16];
  assign ver    = view[TOP-8*OFF_VER-1   -: 16];
  assign code   = view[TOP-8*OFF_CODE-1  -: 16];
  assign is_ack = (code == ACK_CODE);
  assign hdr_ok = (proto == PROTO_ID) && (ver == PROTO_VER);
  assign long_enough = total >= BYTE_W'(is_ack ? ACK_MIN : CMD_MIN);
  assign accept = frame_end && hdr_ok && long_enough;

  always_comb begin
    rec.is_ack = is_ack;
    rec.src    = view[TOP-8*OFF_SRC-1 -: 48];
    rec.code   = code;
    rec.seq    = view[TOP-8*OFF_SEQ-1 -: 16];
    rec.arg    = view[TOP-8*OFF_ARG-1 -: 32];
    rec.delay  = is_ack ? view[TOP-8*OFF_DLY-1 -: 32] : 32'h0;
  end
endmodule

// File: rtl/cfp_fifo.sv
module cfp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         not_empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push;

  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign do_pop    = pop && not_empty;
  assign do_push   = push && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rdata = mem[rd_q];
endmodule

// File: rtl/ctlframe_parser.sv
module ctlframe_parser
  import cfp_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DEPTH  = 2,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [8*LANES-1:0] in_data,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic [LANES-1:0]   in_keep,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_is_ack,
  output logic [47:0]        out_src,
  output logic [15:0]        out_code,
  output logic [15:0]        out_seq,
  output logic [31:0]        out_arg,
  output logic [31:0]        out_delay,
  output logic [CNT_W-1:0]   drop_cnt
);
  localparam int REC_W = $bits(rec_t);

  logic [8*HDR_BYTES-1:0] view;
  logic [BYTE_W-1:0]      total;
  logic                   frame_end, accept, q_full, can_take;
  rec_t                   new_rec, head_rec;
  logic [CNT_W-1:0]       drop_q;

  cfp_capture #(.LANES(LANES), .BYTE_W(BYTE_W)) u_cap (
    .clk, .rst, .in_data, .in_valid, .in_last, .in_keep,
    .view, .total, .frame_end
  );

  cfp_decide #(.BYTE_W(BYTE_W)) u_dec (
    .view, .total, .frame_end, .accept, .rec(new_rec)
  );

  assign can_take = !q_full || (out_valid && out_ready);

  cfp_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_q (
    .clk, .rst,
    .push(accept), .wdata(new_rec),
    .pop(out_ready), .rdata(head_rec),
    .not_empty(out_valid), .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (rst) drop_q <= '0;
    else if (accept && !can_take) drop_q <= drop_q + 1'b1;
  end

  assign drop_cnt   = drop_q;
  assign out_is_ack = head_rec.is_ack;
  assign out_src    = head_rec.src;
  assign out_code   = head_rec.code;
  assign out_seq    = head_rec.seq;
  assign out_arg    = head_rec.arg;
  assign out_delay  = head_rec.delay;
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_is_ack,
  input logic [47:0]      out_src,
  input logic [15:0]      out_code,
  input logic [15:0]      out_seq,
  input logic [31:0]      out_arg,
  input logic [31:0]      out_delay,
  input logic [CNT_W-1:0] drop_cnt
);
  a_r3_ack_code: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_ack |-> out_code == 16'h0003);

  a_r4_cmd_fields: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is_ack |-> out_code != 16'h0003 && out_delay == 32'h0);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_is_ack, out_src, out_code, out_seq, out_arg, out_delay}));

  a_r7_after_last: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_last));

  a_r9_drop_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(drop_cnt) |-> drop_cnt == $past(drop_cnt) + CNT_W'(1));

  a_r9_drop_cause: assert property (@(posedge clk) disable iff (rst)
    !$stable(drop_cnt) |-> $past(in_valid && in_last && out_valid));
endmodule

bind ctlframe_parser cfp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
  .out_valid(out_valid), .out_ready(out_ready), .out_is_ack(out_is_ack),
  .out_src(out_src), .out_code(out_code), .out_seq(out_seq),
  .out_arg(out_arg), .out_delay(out_delay), .drop_cnt(drop_cnt)
);

// File: tb/sim_ctlframe_parser.sv
module sim_ctlframe_parser;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int DEPTH = 2;
  localparam int CNT_W = 8;
  localparam int RW    = 145;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8*LANES-1:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [LANES-1:0] in_keep = '0;
  logic out_ready = 1'b0;
  logic out_valid, out_is_ack;
  logic [47:0] out_src;
  logic [15:0] out_code, out_seq;
  logic [31:0] out_arg, out_delay;
  logic [CNT_W-1:0] drop_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlframe_parser #(.LANES(LANES), .DEPTH(DEPTH), .BYTE_W(8), .CNT_W(CNT_W)) u0 (
    .clk, .rst, .in_data, .in_valid, .in_last, .in_keep,
    .out_valid, .out_ready, .out_is_ack, .out_src, .out_code, .out_seq,
    .out_arg, .out_delay, .drop_cnt
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0]    fb [0:127];
  logic [RW-1:0] q_rec [0:63];
  int q_head = 0, q_tail = 0, exp_drop = 0;

  task automatic chk(input bit ok, input string tag, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  function automatic logic [RW-1:0] got_rec();
    return {out_is_ack, out_src, out_code, out_seq, out_arg, out_delay};
  endfunction

  task automatic build(input logic [15:0] proto, input logic [15:0] ver,
                       input logic [15:0] code, input logic [15:0] s16,
                       input logic [31:0] w32, input logic [31:0] d32,
                       input int seed);
    for (int i = 0; i < 128; i++) fb[i] = 8'(seed*7 + i*13 + 5);
    for (int i = 0; i < 6; i++) fb[6+i] = 8'(seed + 16*i + 1);
    fb[12] = proto[15:8]; fb[13] = proto[7:0];
    fb[14] = ver[15:8];   fb[15] = ver[7:0];
    fb[16] = code[15:8];  fb[17] = code[7:0];
    fb[18] = s16[15:8];   fb[19] = s16[7:0];
    for (int i = 0; i < 4; i++) fb[20+i] = w32[31-8*i -: 8];
    if (code == 16'h0003)
      for (int i = 0; i < 4; i++) fb[24+i] = d32[31-8*i -: 8];
  endtask

  // Sends fb[0..len-1]; gap inserts an idle cycle after beat 0 (R10)
  task automatic send(input int len, input bit gap, input bit pop_last);
    logic [15:0] p, v, c;
    bit ack, good;
    int beats, pend;
    logic [RW-1:0] er;
    p = {fb[12], fb[13]}; v = {fb[14], fb[15]}; c = {fb[16], fb[17]};
    ack  = (c == 16'h0003);
    good = (p == 16'hFADE) && (v == 16'h0100) && (len >= (ack ? 28 : 24));
    er = {ack, fb[6], fb[7], fb[8], fb[9], fb[10], fb[11], c, fb[18], fb[19],
          fb[20], fb[21], fb[22], fb[23],
          ack ? {fb[24], fb[25], fb[26], fb[27]} : 32'h0};
    beats = (len + LANES - 1) / LANES;
    for (int b = 0; b < beats; b++) begin
      if (gap && b == 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
      end
      @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
        int idx;
        idx = b*LANES + l;
        in_data[8*(LANES-l)-1 -: 8] = (idx < len) ? fb[idx] : 8'h00;
        in_keep[l] = (idx < len);
      end
      in_valid = 1'b1;
      in_last  = (b == beats - 1);
      if (b == beats - 1) begin
        pend = q_tail - q_head;
        if (pend == 0)
          chk(out_valid == 1'b0, "R7",
              $sformatf("out_valid before last edge got %0b exp 0", out_valid));
        if (pop_last) begin
          chk(out_valid && got_rec() == q_rec[q_head % 64], "R11",
              $sformatf("head got %h exp %h", got_rec(), q_rec[q_head % 64]));
          out_ready = 1'b1;
          q_head++;
        end
        if (good) begin
          if ((q_tail - q_head) >= DEPTH) exp_drop++;
          else begin
            q_rec[q_tail % 64] = er;
            q_tail++;
          end
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_keep = '0; out_ready = 1'b0;
  endtask

  task automatic drain(input string tag);
    while (q_head != q_tail) begin
      chk(out_valid && got_rec() == q_rec[q_head % 64], tag,
          $sformatf("valid=%0b got %h exp %h", out_valid, got_rec(), q_rec[q_head % 64]));
      out_ready = 1'b1;
      q_head++;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(out_valid == 1'b0, "R2 R6", $sformatf("extra record valid got %0b exp 0", out_valid));
    chk(drop_cnt == CNT_W'(exp_drop), "R9",
        $sformatf("drop_cnt got %0d exp %0d", drop_cnt, exp_drop));
  endtask

  initial begin
    int lens [6] = '{16, 23, 24, 27, 28, 78};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && drop_cnt == '0, "R1",
        $sformatf("reset got valid=%0b drop=%0d exp 0/0", out_valid, drop_cnt));

    // Sweep: kind x length x idle gap (R2 R3 R4 R5 R6 R10)
    for (int k = 0; k < 5; k++) begin
      for (int li = 0; li < 6; li++) begin
        for (int g = 0; g < 2; g++) begin
          int s;
          s = k*37 + li*11 + g*5;
          case (k)
            0: build(16'hFADE, 16'h0100, 16'h0003, 16'(s*3+1), 32'(s*1000+7), 32'(s*77+3), s);
            1: build(16'hFADE, 16'h0100, 16'h0001, 16'(s+9), 32'hA5000000 + 32'(s), 32'h0, s);
            2: build(16'hFADE, 16'h0100, 16'h8003, 16'(s), 32'(s*31), 32'h0, s);
            3: build(16'hFADF, 16'h0100, 16'h0003, 16'(s), 32'(s), 32'(s), s);
            default: build(16'hFADE, 16'h0101, 16'h0002, 16'(s), 32'(s), 32'h0, s);
          endcase
          send(lens[li], g[0], 1'b0);
          drain(g ? "R10 R5" : (k == 0 ? "R3 R5" : "R4 R5"));
        end
      end
    end

    // Full-queue behaviour (R8 R9 R11)
    build(16'hFADE, 16'h0100, 16'h0003, 16'h0011, 32'h01020304, 32'h0A0B0C0D, 3);
    send(78, 1'b0, 1'b0);
    build(16'hFADE, 16'h0100, 16'h0042, 16'h0022, 32'hDEADBEEF, 32'h0, 4);
    send(24, 1'b0, 1'b0);
    build(16'hFADE, 16'h0100, 16'h0003, 16'h0033, 32'h11111111, 32'h22222222, 5);
    send(28, 1'b0, 1'b0);   // dropped and counted
    build(16'hBEEF, 16'h0100, 16'h0003, 16'h0044, 32'h0, 32'h0, 6);
    send(78, 1'b0, 1'b0);   // bad header, not counted
    repeat (5) @(negedge clk);
    chk(out_valid && got_rec() == q_rec[q_head % 64], "R8",
        $sformatf("held head got %h exp %h", got_rec(), q_rec[q_head % 64]));
    chk(drop_cnt == CNT_W'(exp_drop), "R9",
        $sformatf("drop_cnt got %0d exp %0d", drop_cnt, exp_drop));
    build(16'hFADE, 16'h0100, 16'h0077, 16'h0055, 32'hCAFEF00D, 32'h0, 7);
    send(40, 1'b1, 1'b1);   // push with simultaneous pop while full
    chk(drop_cnt == CNT_W'(exp_drop), "R11",
        $sformatf("drop_cnt got %0d exp %0d", drop_cnt, exp_drop));
    drain("R8");

    finish_run();
  end
endmodule